// File: doc/BRIEF.md
# Serial Byte-Memory Slave Controller

This block is a serial peripheral interface slave that gives an outside host byte access to a 2048-byte on-chip array. The array is organised as 256 rows of eight byte columns. The host pulls chip select low and shifts in an 8-bit command. A 16-bit address field follows, and only its low 11 bits are used. After that the host streams bytes in (write) or out (read) for as long as chip select stays low, and the byte address steps forward after every byte.

The serial pins are sampled in mode 0: data enters on the rising clock edge, the output changes on the falling edge, and the serial clock rests low. All pins are brought into the system clock domain through synchronisers, so the serial clock half-period must be at least four system clocks. The array sits outside the block and is reached through a single-cycle strobe port: the read data must be valid combinationally in the cycle `memRe` is high. A write command only takes effect after a write-enable command was sent in an earlier chip-select frame. A row strobe marks every access that opens a row not yet touched in the current frame, so a wear counter can tally row accesses instead of byte accesses.

Top module: `sermem_slave`

## Requirements
- R1: After reset `soEn`, `memRe`, `memWe` and `rowStrobe` are all low.
- R2: Command 8'h03 followed by a 16-bit address, both MSB first, starts a read. The five upper address bits are ignored. `memRe` fetches the byte at the low 11 bits, and that byte is driven MSB first on `soData`, changing on falling serial clock edges, starting at the falling edge right after the last address bit. Each `memRe` and `memWe` pulse lasts one clock, and the two are never high together.
- R3: During a burst the byte address rises by one after each byte, and it wraps from 11'h7FF to 11'h000. This holds for reads and for writes.
- R4: Command 8'h02 with the write-enable latch set writes each completed 8-bit input byte (MSB first) with a single `memWe` pulse carrying the byte address and the data.
- R5: Command 8'h06 sets the write-enable latch only when chip select rises to end its frame. Without the latch set, a write command causes no `memWe`.
- R6: The write-enable latch is cleared when chip select rises after any frame that carried command 8'h02.
- R7: `soEn` is low during the command and address phases and for the whole of a write frame. It is high while read data bits are being driven, and it drops within four clocks after chip select rises.
- R8: `rowStrobe` is a one-clock pulse that coincides with a `memRe` or `memWe` pulse. It fires on the first access of a frame, and on any later access whose row (address bits 10 to 3) differs from the row of the previous access in that frame.
- R9: Raising chip select in the middle of a byte discards the partial byte: a write byte that is not complete produces no `memWe`, and the next frame starts with a fresh command.
- R10: Any other command value causes no memory access and no output until chip select rises. The following frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| soData | output | 1 | Serial data out value |
| soEn | output | 1 | Serial data out drive enable (high-impedance when low) |
| memAddr | output | 11 | Array byte address for the current strobe |
| memRe | output | 1 | One-clock read strobe |
| memWe | output | 1 | One-clock write strobe |
| memWdata | output | 8 | Write data, valid with `memWe` |
| memRdata | input | 8 | Read data, valid combinationally while `memRe` is high |
| rowStrobe | output | 1 | One-clock pulse on each newly opened row |

## Verification
The checker watches on every clock that the strobes last one clock and never overlap, that a row pulse always rides on an access, and that the serial output stays undriven whenever a write strobe fires. Only the bench's scenarios can show the frame-level behaviour: that the write-enable latch is set at the end of the frame and cleared afterwards, that addresses wrap, that a partial byte is dropped, that unknown commands are silent, and that read data arrives bit for bit in order. A scoreboard compares every memory access, its address, data and row flag, against a queue filled from the requirements.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_WREN,
    ST_SKIP
  } sermemState_e;

  typedef struct packed {
    logic rxShift;
    logic addrShift;
    logic memRead;
    logic memWrite;
    logic soLoad;
    logic soShift;
    logic idle;
  } sermemCtl_t;

  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WREN  = 8'h06;

endpackage

// File: rtl/sermem_ctrl.sv
module sermem_ctrl
  import sermem_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_FIELD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csS,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic [DATA_W-1:0] rxNext,
  output sermemCtl_t        ctl
);

  localparam int CNT_W = $clog2(ADDR_FIELD_W + 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_FIELD_W - 1);

  sermemState_e state;
  logic [CNT_W-1:0] bitCnt;
  logic wel;
  logic cmdRead;
  logic wrCmdSeen;
  logic wrenSeen;
  logic readPend;
  logic csPrev;

  wire csRise = csS & ~csPrev;

  always_comb begin
    ctl = '0;
    ctl.idle    = csS;
    ctl.memRead = readPend;
    if (!csS) begin
      if (sckRise) begin
        ctl.rxShift   = 1'b1;
        ctl.addrShift = (state == ST_ADDR);
        ctl.memWrite  = (state == ST_WRITE) && (bitCnt == BYTE_LAST) && wel;
      end
      if (sckFall && state == ST_READ) begin
        ctl.soLoad  = (bitCnt == '0);
        ctl.soShift = (bitCnt != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_OPCODE;
      bitCnt    <= '0;
      wel       <= 1'b0;
      cmdRead   <= 1'b0;
      wrCmdSeen <= 1'b0;
      wrenSeen  <= 1'b0;
      readPend  <= 1'b0;
      csPrev    <= 1'b1;
    end else begin
      csPrev   <= csS;
      readPend <= 1'b0;
      if (csS) begin
        state     <= ST_OPCODE;
        bitCnt    <= '0;
        wrCmdSeen <= 1'b0;
        wrenSeen  <= 1'b0;
        if (csRise) begin
          if (wrenSeen)  wel <= 1'b1;
          if (wrCmdSeen) wel <= 1'b0;
        end
      end else if (sckRise) begin
        case (state)
          ST_OPCODE: begin
            if (bitCnt == BYTE_LAST) begin
              bitCnt <= '0;
              case (rxNext)
                OP_WRITE: begin
                  state     <= ST_ADDR;
                  cmdRead   <= 1'b0;
                  wrCmdSeen <= 1'b1;
                end
                OP_READ: begin
                  state   <= ST_ADDR;
                  cmdRead <= 1'b1;
                end
                OP_WREN: begin
                  state    <= ST_WREN;
                  wrenSeen <= 1'b1;
                end
                default: state <= ST_SKIP;
              endcase
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_ADDR: begin
            if (bitCnt == ADDR_LAST) begin
              bitCnt   <= '0;
              state    <= cmdRead ? ST_READ : ST_WRITE;
              readPend <= cmdRead;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_WRITE: bitCnt <= (bitCnt == BYTE_LAST) ? '0 : bitCnt + 1'b1;
          ST_READ: begin
            if (bitCnt == BYTE_LAST) begin
              bitCnt   <= '0;
              readPend <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sermem_dp.sv
module sermem_dp
  import sermem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              siS,
  input  sermemCtl_t        ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] rxNext,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              rowStrobe,
  output logic              soData,
  output logic              soEn
);

  localparam int ROW_W = ADDR_W - COL_W;

  logic [DATA_W-2:0] rxReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] rdBuf;
  logic [DATA_W-1:0] soReg;
  logic [ROW_W-1:0]  lastRow;
  logic              rowValid;

  wire [ROW_W-1:0] curRow = addrReg[ADDR_W-1:COL_W];
  wire             access = ctl.memRead | ctl.memWrite;

  assign rxNext = {rxReg, siS};
  assign soData = soReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg     <= '0;
      addrReg   <= '0;
      memAddr   <= '0;
      memRe     <= 1'b0;
      memWe     <= 1'b0;
      memWdata  <= '0;
      rowStrobe <= 1'b0;
      rdBuf     <= '0;
      soReg     <= '0;
      soEn      <= 1'b0;
      lastRow   <= '0;
      rowValid  <= 1'b0;
    end else begin
      memRe     <= ctl.memRead;
      memWe     <= ctl.memWrite;
      rowStrobe <= 1'b0;
      if (ctl.rxShift)   rxReg   <= rxNext[DATA_W-2:0];
      if (ctl.addrShift) addrReg <= {addrReg[ADDR_W-2:0], siS};
      if (access) begin
        memAddr   <= addrReg;
        addrReg   <= addrReg + 1'b1;
        memWdata  <= rxNext;
        rowStrobe <= !rowValid || (curRow != lastRow);
        lastRow   <= curRow;
        rowValid  <= 1'b1;
      end
      if (memRe) rdBuf <= memRdata;
      if (ctl.soLoad) begin
        soReg <= rdBuf;
        soEn  <= 1'b1;
      end else if (ctl.soShift) begin
        soReg <= {soReg[DATA_W-2:0], 1'b0};
      end
      if (ctl.idle) begin
        soEn     <= 1'b0;
        rowValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sermem_slave.sv
module sermem_slave
  import sermem_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int COL_W        = 3,
  parameter int ADDR_FIELD_W = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  output logic              soData,
  output logic              soEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rowStrobe
);

  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] sckPipe;
  logic [SYNC_STAGES-1:0] siPipe;
  logic                   sckPrev;
  logic [DATA_W-1:0]      rxNext;
  sermemCtl_t             ctl;

  wire csS  = csPipe[SYNC_STAGES-1];
  wire sckS = sckPipe[SYNC_STAGES-1];
  wire siS  = siPipe[SYNC_STAGES-1];
  wire sckRise = sckS & ~sckPrev;
  wire sckFall = ~sckS & sckPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPipe  <= '1;
      sckPipe <= '0;
      siPipe  <= '0;
      sckPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csN};
      sckPipe <= {sckPipe[SYNC_STAGES-2:0], sck};
      siPipe  <= {siPipe[SYNC_STAGES-2:0], si};
      sckPrev <= sckS;
    end
  end

  sermem_ctrl #(
    .DATA_W      (DATA_W),
    .ADDR_FIELD_W(ADDR_FIELD_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csS    (csS),
    .sckRise(sckRise),
    .sckFall(sckFall),
    .rxNext (rxNext),
    .ctl    (ctl)
  );

  sermem_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .COL_W (COL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .siS      (siS),
    .ctl      (ctl),
    .memRdata (memRdata),
    .rxNext   (rxNext),
    .memAddr  (memAddr),
    .memRe    (memRe),
    .memWe    (memWe),
    .memWdata (memWdata),
    .rowStrobe(rowStrobe),
    .soData   (soData),
    .soEn     (soEn)
  );

endmodule

// File: rtl/sermem_checks.sv
module sermem_checks (
  input logic clk,
  input logic rstN,
  input logic memRe,
  input logic memWe,
  input logic rowStrobe,
  input logic soEn
);

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe); // R4

  AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !memRe); // R2

  AST_NO_RE_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R2

  AST_ROW_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe |-> (memRe || memWe)); // R8

  AST_ROW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rowStrobe |=> !rowStrobe); // R8

  AST_SO_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !soEn); // R7

endmodule

bind sermem_slave sermem_checks u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .memRe    (memRe),
  .memWe    (memWe),
  .rowStrobe(rowStrobe),
  .soEn     (soEn)
);

// File: tb/test_sermem_slave.sv
`timescale 1ns/1ps
module test_sermem_slave;

  localparam int HALF = 5;

  typedef struct packed {
    logic        wr;
    logic [10:0] addr;
    logic [7:0]  data;
    logic        rowNew;
  } acc_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic soData, soEn, memRe, memWe, rowStrobe;
  logic [10:0] memAddr;
  logic [7:0] memWdata, memRdata;

  logic [7:0] envMem [2048];
  logic [7:0] refMem [2048];
  acc_t expQ [$];
  int checkCnt = 0;
  int failCnt = 0;
  int lastRowExp = -1;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sermem_slave i_sermem_slave (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .soData(soData), .soEn(soEn), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .rowStrobe(rowStrobe)
  );

  assign memRdata = envMem[memAddr];

  always @(posedge clk) if (memWe) envMem[memAddr] <= memWdata;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && (memWe || memRe)) begin
      if (expQ.size() == 0) begin
        check(1'b0, memWe ? "R5" : "R10", "unexpected access addr", int'(memAddr), 0);
      end else begin
        acc_t e;
        e = expQ.pop_front();
        check(memWe == e.wr, "R4", "access kind", int'(memWe), int'(e.wr));
        check(memAddr == e.addr, "R3", "access address", int'(memAddr), int'(e.addr));
        if (e.wr) check(memWdata == e.data, "R4", "write data", int'(memWdata), int'(e.data));
        check(rowStrobe == e.rowNew, "R8", "row strobe", int'(rowStrobe), int'(e.rowNew));
      end
    end
  end

  function automatic void pushAcc(input bit wr, input int a, input logic [7:0] d);
    acc_t e;
    int row;
    row = (a & 11'h7FF) >> 3;
    e.wr = wr;
    e.addr = 11'(a);
    e.data = d;
    e.rowNew = (row != lastRowExp);
    lastRowExp = row;
    expQ.push_back(e);
  endfunction

  task automatic sendBit(input bit b, output bit o, input bit quiet, input string req);
    @(negedge clk) si = b;
    repeat (HALF) @(negedge clk);
    o = soData;
    if (quiet) check(soEn == 1'b0, req, "soEn quiet", int'(soEn), 0);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] tx, output logic [7:0] rx,
                          input bit quiet, input string req);
    for (int i = 7; i >= 0; i--) begin
      bit o;
      sendBit(tx[i], o, quiet, req);
      rx[i] = o;
    end
  endtask

  task automatic frameOpen();
    @(negedge clk) csN = 1'b0;
    lastRowExp = -1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frameClose();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic sendHeader(input logic [7:0] op, input int a, input string req);
    logic [7:0] dummy;
    logic [15:0] field;
    field = {5'b10110, 11'(a)};
    sendByte(op, dummy, 1'b1, req);
    sendByte(field[15:8], dummy, 1'b1, req);
    sendByte(field[7:0], dummy, 1'b1, req);
  endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 13 + seed) & 8'hFF);
  endfunction

  task automatic doWren();
    logic [7:0] dummy;
    frameOpen();
    sendByte(8'h06, dummy, 1'b1, "R5");
    frameClose();
  endtask

  task automatic doWrite(input int a, input int n, input int seed,
                         input bit honored, input string req);
    logic [7:0] dummy;
    frameOpen();
    sendHeader(8'h02, a, "R7");
    for (int i = 0; i < n; i++) begin
      int ad;
      ad = (a + i) & 11'h7FF;
      if (honored) begin
        pushAcc(1'b1, ad, pat(ad, seed));
        refMem[ad] = pat(ad, seed);
      end
      sendByte(pat(ad, seed), dummy, 1'b1, "R7");
    end
    frameClose();
    check(expQ.size() == 0, req, "pending writes after frame", expQ.size(), 0);
  endtask

  task automatic doRead(input int a, input int n, input string req);
    logic [7:0] rx;
    frameOpen();
    for (int i = 0; i <= n; i++) pushAcc(1'b0, (a + i) & 11'h7FF, 8'h00);
    sendHeader(8'h03, a, "R7");
    for (int i = 0; i < n; i++) begin
      int ad;
      ad = (a + i) & 11'h7FF;
      sendByte(8'h00, rx, 1'b0, req);
      check(rx == refMem[ad], req, "read byte", int'(rx), int'(refMem[ad]));
      check(soEn == 1'b1, "R7", "soEn while reading", int'(soEn), 1);
    end
    frameClose();
    check(soEn == 1'b0, "R7", "soEn after frame", int'(soEn), 0);
    check(expQ.size() == 0, req, "pending reads after frame", expQ.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      envMem[i] = 8'((i * 7 + 3) & 8'hFF);
      refMem[i] = 8'((i * 7 + 3) & 8'hFF);
    end
    repeat (6) @(negedge clk);
    check(soEn == 1'b0 && memRe == 1'b0 && memWe == 1'b0 && rowStrobe == 1'b0,
          "R1", "outputs in reset", int'({soEn, memRe, memWe, rowStrobe}), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(soEn == 1'b0 && memRe == 1'b0 && memWe == 1'b0,
          "R1", "outputs after reset", int'({soEn, memRe, memWe}), 0);

    // R5: write with no prior write-enable frame is ignored
    doWrite(11'h010, 2, 1, 1'b0, "R5");
    doRead(11'h010, 2, "R5");

    // R4, R8, R2: enabled burst write crossing a row boundary, top field bits junk
    doWren();
    doWrite(11'h005, 5, 2, 1'b1, "R4");

    // R6: latch was cleared by the previous write frame
    doWrite(11'h005, 3, 9, 1'b0, "R6");

    // R2, R8: burst read back across the row boundary
    doRead(11'h005, 5, "R2");

    // R3: wrap at the top of the array, write then read
    doWren();
    doWrite(11'h7FE, 3, 4, 1'b1, "R3");
    doRead(11'h7FE, 4, "R3");

    // R9: full byte then a partial byte, then chip select rises
    doWren();
    begin
      logic [7:0] dummy;
      frameOpen();
      sendHeader(8'h02, 11'h100, "R7");
      pushAcc(1'b1, 11'h100, 8'h3C);
      refMem[11'h100] = 8'h3C;
      sendByte(8'h3C, dummy, 1'b1, "R9");
      for (int i = 0; i < 5; i++) begin
        bit o;
        sendBit(1'b1, o, 1'b1, "R9");
      end
      frameClose();
      check(expQ.size() == 0, "R9", "pending after abort", expQ.size(), 0);
    end
    doRead(11'h100, 2, "R9");

    // R10: unknown command stays silent, next frame decodes normally
    begin
      logic [7:0] dummy;
      frameOpen();
      sendByte(8'h55, dummy, 1'b1, "R10");
      sendByte(8'h03, dummy, 1'b1, "R10");
      sendByte(8'h00, dummy, 1'b1, "R10");
      sendByte(8'h02, dummy, 1'b1, "R10");
      frameClose();
      check(expQ.size() == 0, "R10", "queue after unknown command", expQ.size(), 0);
    end
    doRead(11'h120, 2, "R10");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

endmodule